// File: doc/BRIEF.md
# TLB Management Register Port

This block is the software-facing side of a translation lookaside buffer. It owns the entry storage (a tag word, a data word and an 8-bit owner tag per entry) together with an index register, a process-identifier register and a zone-protection register. Software never addresses an entry directly. It first loads the index register. It then reads or writes the tag or data selector, and the block applies that access to the entry the index points at.

Three accesses have side effects. Writing a tag stamps the entry with the current process identifier. Writing a tag over a valid entry also emits a flush request for the mapping being replaced. Reading a tag copies the entry's owner tag back into the process-identifier register.

A write to the search selector sends the written page number to an external translation matcher for a read-type lookup. That matcher applies the current privilege level, as normal translation does. Its answer arrives in the same cycle. A hit loads the matching slot into the index register, and a miss marks the index register as a failure.

Changing the process identifier or the zone register starts a background walk, one entry per cycle. The walk flushes every valid entry that belongs to the outgoing process.

Top module: `tlb_mgmt_port`

## Requirements
- R1: After a synchronous reset (rst_n low at a clock edge), every register and every entry reads zero, so all entries are invalid. busy, flush_req and pid_illegal are low.
- R2: reg_sel encodes the registers as follows: 0 index, 1 process identifier, 2 zone, 3 entry tag, 4 entry data, 5 search. Selectors 3 and 4 access the entry at index register bits [IDX_W-1:0]. A write takes effect at the clock edge, and reg_rdata shows the addressed word combinationally.
- R3: A tag write stores the low 8 bits of the process identifier as the entry's owner tag. If the entry's old tag had bit 6 (valid) set, flush_req is high for one cycle after the write edge, with flush_idx set to that entry.
- R4: A tag read (reg_re with selector 3 and reg_we low) loads the process identifier with the entry's owner tag, zero-extended. The new value is visible from the next cycle.
- R5: A search write raises srch_valid in the same cycle. srch_vpn carries the written value with bits [PAGE_LSB-1:0] cleared. If srch_hit is high, the index register becomes srch_idx, zero-extended.
- R6: If srch_hit is low during a search write, bit 31 of the index register is set and its other bits keep their values.
- R7: A write to the process identifier or zone register with a value equal to the stored one changes nothing and starts no walk. A different value is stored, and busy is then high for exactly ENTRIES cycles.
- R8: During a walk, each entry is visited in ascending order. flush_req pulses for an entry exactly when that entry is valid and its owner tag is nonzero and equals bits [7:0] of the process identifier held before the triggering write.
- R9: While busy is high, register writes have no effect, a tag read does not load the process identifier, and srch_valid stays low.
- R10: Any write to selector 1 with a nonzero bit in [31:8] makes pid_illegal high for one cycle after the edge, even when the write is otherwise ignored.
- R11: Selector 0 is a plain read/write register. Selector 5 and the unused selectors 6 and 7 read zero. Writes to selectors 6 and 7 do nothing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous reset, active low |
| reg_we | input | 1 | Register write strobe |
| reg_re | input | 1 | Register read strobe (matters for the tag selector) |
| reg_sel | input | 3 | Register selector |
| reg_wdata | input | 32 | Write data |
| reg_rdata | output | 32 | Read data for the selected register |
| srch_valid | output | 1 | Lookup request to the external matcher |
| srch_vpn | output | 32 | Page number to look up, offset bits cleared |
| srch_hit | input | 1 | Matcher found an entry |
| srch_idx | input | IDX_W | Slot reported by the matcher |
| flush_req | output | 1 | One-cycle flush request |
| flush_idx | output | IDX_W | Entry to flush |
| busy | output | 1 | Identifier-change walk in progress |
| pid_illegal | output | 1 | Out-of-range process identifier was written |

## Verification
The bench targets the side effects that hang off plain accesses:
- **Tag read.** A design that ignored this side effect would leave the process identifier unchanged.
- **Tag rewrite.** A design that flushed on every tag write, rather than only over a valid entry, would emit spurious flushes.
- **Search miss.** A design that cleared the index instead of only setting its top bit would redirect the next access to entry zero.
- **Walk matching.** Entries are owned by the outgoing identifier, by an unowned (zero) tag, and by a different identifier, and some are invalid. A design that compared against the new identifier or skipped the validity test would flush the wrong set.
- **Writes during the walk.** A design that applied these would corrupt entries while the walk is still running.
- **Unchanged values.** Rewriting the identifier or zone register with its current value must not start a walk.

// File: rtl/tlb_mgmt_port.sv
module tlb_mgmt_port #(
  parameter int ENTRIES   = 64,
  parameter int PAGE_LSB  = 10,
  parameter int VALID_BIT = 6,
  localparam int IDX_W    = $clog2(ENTRIES)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             reg_we,
  input  logic             reg_re,
  input  logic [2:0]       reg_sel,
  input  logic [31:0]      reg_wdata,
  output logic [31:0]      reg_rdata,
  output logic             srch_valid,
  output logic [31:0]      srch_vpn,
  input  logic             srch_hit,
  input  logic [IDX_W-1:0] srch_idx,
  output logic             flush_req,
  output logic [IDX_W-1:0] flush_idx,
  output logic             busy,
  output logic             pid_illegal
);
  localparam logic [2:0] SEL_INDEX = 3'd0, SEL_PID = 3'd1, SEL_ZONE = 3'd2,
                         SEL_TAG = 3'd3, SEL_DATA = 3'd4, SEL_SRCH = 3'd5;

  logic [31:0]      idx_q, pid_q, zone_q;
  logic [31:0]      tag_mem  [ENTRIES];
  logic [31:0]      data_mem [ENTRIES];
  logic [7:0]       tid_mem  [ENTRIES];
  logic             busy_q, flush_q, ill_q;
  logic [IDX_W-1:0] ptr_q, fidx_q;
  logic [7:0]       spid_q;

  wire [IDX_W-1:0] ent      = idx_q[IDX_W-1:0];
  wire             wr       = reg_we && !busy_q;
  wire             pid_chg  = wr && reg_sel == SEL_PID  && reg_wdata != pid_q;
  wire             zone_chg = wr && reg_sel == SEL_ZONE && reg_wdata != zone_q;
  wire             tag_rd   = reg_re && !reg_we && !busy_q && reg_sel == SEL_TAG;
  wire             scan_hit = tag_mem[ptr_q][VALID_BIT] && tid_mem[ptr_q] != 8'd0 &&
                              tid_mem[ptr_q] == spid_q;

  assign srch_valid  = wr && reg_sel == SEL_SRCH;
  assign srch_vpn    = {reg_wdata[31:PAGE_LSB], {PAGE_LSB{1'b0}}};
  assign flush_req   = flush_q;
  assign flush_idx   = fidx_q;
  assign busy        = busy_q;
  assign pid_illegal = ill_q;

  always_comb begin
    case (reg_sel)
      SEL_INDEX: reg_rdata = idx_q;
      SEL_PID:   reg_rdata = pid_q;
      SEL_ZONE:  reg_rdata = zone_q;
      SEL_TAG:   reg_rdata = tag_mem[ent];
      SEL_DATA:  reg_rdata = data_mem[ent];
      default:   reg_rdata = 32'd0;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      idx_q   <= '0;
      pid_q   <= '0;
      zone_q  <= '0;
      busy_q  <= 1'b0;
      flush_q <= 1'b0;
      ill_q   <= 1'b0;
      ptr_q   <= '0;
      fidx_q  <= '0;
      spid_q  <= '0;
      for (int i = 0; i < ENTRIES; i++) begin
        tag_mem[i]  <= '0;
        data_mem[i] <= '0;
        tid_mem[i]  <= '0;
      end
    end else begin
      flush_q <= 1'b0;
      ill_q   <= reg_we && reg_sel == SEL_PID && |reg_wdata[31:8];
      if (busy_q) begin
        flush_q <= scan_hit;
        fidx_q  <= ptr_q;
        ptr_q   <= ptr_q + 1'b1;
        if (ptr_q == IDX_W'(ENTRIES - 1)) busy_q <= 1'b0;
      end else if (pid_chg || zone_chg) begin
        busy_q <= 1'b1;
        ptr_q  <= '0;
        spid_q <= pid_q[7:0];
        if (pid_chg) pid_q  <= reg_wdata;
        else         zone_q <= reg_wdata;
      end else if (wr) begin
        case (reg_sel)
          SEL_INDEX: idx_q <= reg_wdata;
          SEL_TAG: begin
            tag_mem[ent] <= reg_wdata;
            tid_mem[ent] <= pid_q[7:0];
            flush_q      <= tag_mem[ent][VALID_BIT];
            fidx_q       <= ent;
          end
          SEL_DATA: data_mem[ent] <= reg_wdata;
          SEL_SRCH: begin
            if (srch_hit) idx_q <= {{(32-IDX_W){1'b0}}, srch_idx};
            else          idx_q[31] <= 1'b1;
          end
          default: ;
        endcase
      end else if (tag_rd) begin
        pid_q <= {24'd0, tid_mem[ent]};
      end
    end
  end
endmodule

module tlb_mgmt_port_chk #(
  parameter int IDX_W = 6
) (
  input logic             clk,
  input logic             rst_n,
  input logic             reg_we,
  input logic [2:0]       reg_sel,
  input logic [31:0]      reg_wdata,
  input logic             srch_valid,
  input logic             srch_hit,
  input logic [IDX_W-1:0] srch_idx,
  input logic             flush_req,
  input logic             busy,
  input logic             pid_illegal,
  input logic [31:0]      idx_q,
  input logic [31:0]      pid_q
);
  // R7
  walk_start_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(busy) |-> $past(reg_we && (reg_sel == 3'd1 || reg_sel == 3'd2)));

  // R10
  illegal_src_chk: assert property (@(posedge clk) disable iff (!rst_n)
    pid_illegal |-> $past(reg_we && reg_sel == 3'd1 && reg_wdata[31:8] != 24'd0));

  // R5
  search_hit_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (srch_valid && srch_hit) |=> idx_q[IDX_W-1:0] == $past(srch_idx) &&
                                 idx_q[31:IDX_W] == '0);

  // R6
  search_miss_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (srch_valid && !srch_hit) |=> idx_q[31] && idx_q[30:0] == $past(idx_q[30:0]));

  // R3
  flush_src_chk: assert property (@(posedge clk) disable iff (!rst_n)
    flush_req |-> $past(busy || (reg_we && reg_sel == 3'd3)));

  // R9
  busy_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && reg_we) |=> $stable(pid_q) && $stable(idx_q));
endmodule

bind tlb_mgmt_port tlb_mgmt_port_chk #(.IDX_W(IDX_W)) chk_i (
  .clk(clk), .rst_n(rst_n), .reg_we(reg_we), .reg_sel(reg_sel),
  .reg_wdata(reg_wdata), .srch_valid(srch_valid), .srch_hit(srch_hit),
  .srch_idx(srch_idx), .flush_req(flush_req), .busy(busy),
  .pid_illegal(pid_illegal), .idx_q(idx_q), .pid_q(pid_q)
);

// File: tb/tlb_mgmt_port_tb_top.sv
`timescale 1ns/100ps
module tlb_mgmt_port_tb_top;
  localparam int N = 64;
  localparam int IW = 6;

  logic clk = 0, rst_n = 0;
  logic reg_we = 0, reg_re = 0, srch_hit = 0;
  logic [2:0] reg_sel = 0;
  logic [31:0] reg_wdata = 0;
  logic [IW-1:0] srch_idx = 0;
  logic [31:0] reg_rdata, srch_vpn;
  logic srch_valid, flush_req, busy, pid_illegal;
  logic [IW-1:0] flush_idx;

  always #2.5 clk = ~clk;

  tlb_mgmt_port dut_i (.*);

  int checks = 0, errors = 0;
  string cur_req = "R1";
  bit armed = 0;

  logic [31:0] m_idx, m_pid, m_zone;
  logic [31:0] m_tag [N];
  logic [31:0] m_data [N];
  logic [7:0]  m_tid [N];
  bit m_busy, m_flush, m_ill;
  int m_ptr, m_fidx;
  logic [7:0] m_spid;

  function automatic int ent();
    return int'(m_idx % N);
  endfunction

  always @(posedge clk) begin
    if (!rst_n) begin
      m_idx = 0; m_pid = 0; m_zone = 0; m_busy = 0; m_flush = 0; m_ill = 0;
      m_ptr = 0; m_fidx = 0; m_spid = 0;
      for (int i = 0; i < N; i++) begin m_tag[i] = 0; m_data[i] = 0; m_tid[i] = 0; end
    end else begin
      m_flush = 0;
      m_ill = reg_we && reg_sel == 1 && reg_wdata[31:8] != 0;
      if (m_busy) begin
        if (m_tag[m_ptr][6] && m_tid[m_ptr] != 0 && m_tid[m_ptr] == m_spid) begin
          m_flush = 1; m_fidx = m_ptr;
        end
        m_ptr++;
        if (m_ptr == N) m_busy = 0;
      end else if (reg_we) begin
        case (reg_sel)
          0: m_idx = reg_wdata;
          1, 2: begin
            if ((reg_sel == 1 ? m_pid : m_zone) != reg_wdata) begin
              m_spid = m_pid[7:0]; m_busy = 1; m_ptr = 0;
              if (reg_sel == 1) m_pid = reg_wdata; else m_zone = reg_wdata;
            end
          end
          3: begin
            if (m_tag[ent()][6]) begin m_flush = 1; m_fidx = ent(); end
            m_tag[ent()] = reg_wdata; m_tid[ent()] = m_pid[7:0];
          end
          4: m_data[ent()] = reg_wdata;
          5: if (srch_hit) m_idx = 32'(srch_idx); else m_idx[31] = 1'b1;
          default: ;
        endcase
      end else if (reg_re && reg_sel == 3) begin
        m_pid = 32'(m_tid[ent()]);
      end
    end
  end

  function automatic logic [31:0] exp_rdata();
    case (reg_sel)
      0: return m_idx;
      1: return m_pid;
      2: return m_zone;
      3: return m_tag[ent()];
      4: return m_data[ent()];
      default: return 0;
    endcase
  endfunction

  task automatic chk(string req, string what, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
    end
  endtask

  always @(negedge clk) begin
    #1;
    if (armed) begin
      chk(cur_req, "rdata", reg_rdata, exp_rdata());
      chk(cur_req, "busy", 32'(busy), 32'(m_busy));
      chk(cur_req, "flush_req", 32'(flush_req), 32'(m_flush));
      if (m_flush) chk(cur_req, "flush_idx", 32'(flush_idx), 32'(m_fidx));
      chk(cur_req, "pid_illegal", 32'(pid_illegal), 32'(m_ill));
      chk(cur_req, "srch_valid", 32'(srch_valid), 32'(reg_we && reg_sel == 5 && !m_busy));
      if (srch_valid) chk(cur_req, "srch_vpn", srch_vpn, reg_wdata & 32'hFFFF_FC00);
    end
  end

  task automatic wr(logic [2:0] s, logic [31:0] d, logic h = 0, logic [IW-1:0] si = 0);
    @(negedge clk);
    reg_we = 1; reg_re = 0; reg_sel = s; reg_wdata = d; srch_hit = h; srch_idx = si;
  endtask

  task automatic rd(logic [2:0] s);
    @(negedge clk);
    reg_we = 0; reg_re = 1; reg_sel = s;
  endtask

  task automatic idle(int n);
    for (int i = 0; i < n; i++) begin
      @(negedge clk);
      reg_we = 0; reg_re = 0; srch_hit = 0;
    end
  endtask

  initial begin
    #(200000 * 5);
    errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("  Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (3) @(posedge clk);
    @(negedge clk); rst_n = 1; armed = 1;
    cur_req = "R1";
    for (int s = 0; s < 8; s++) rd(3'(s));
    idle(1);

    cur_req = "R2";
    wr(0, 2); wr(4, 32'h1234_5000); wr(3, 32'hABCD_1040);
    rd(3); rd(4); idle(1);
    cur_req = "R11";
    rd(0); wr(6, 32'hFFFF_FFFF); rd(6); rd(7); rd(5); idle(1);

    cur_req = "R7";
    wr(1, 5); idle(N + 3);
    wr(1, 5); idle(3);

    cur_req = "R3";
    wr(3, 32'h0000_2040);
    wr(0, 3); wr(3, 32'h0000_3040);
    wr(0, 7); wr(3, 32'h0000_7000);
    wr(0, 9); wr(1, 0); wr(1, 5);
    idle(N + 2);
    wr(3, 32'h0000_9040);
    wr(0, 11); wr(3, 32'h0000_B040);
    wr(1, 0); idle(N + 2);
    wr(3, 32'h0000_B040);
    wr(1, 5); idle(N + 2);

    cur_req = "R8";
    wr(1, 9);
    cur_req = "R9";
    wr(0, 3); wr(4, 32'hDEAD_BEEF); rd(3); wr(5, 32'h3000, 1, 3);
    idle(N + 2);
    cur_req = "R8";
    wr(0, 3); rd(3); rd(4); idle(1);

    cur_req = "R4";
    wr(0, 2); rd(3); idle(1); rd(1); idle(1);

    cur_req = "R5";
    wr(5, 32'h0000_33FF, 1, 3); rd(0); idle(1);
    cur_req = "R6";
    wr(5, 32'h0001_0123, 0, 0); rd(0); rd(3); idle(1);
    wr(5, 32'h0001_0123, 0, 0); rd(0); idle(1);

    cur_req = "R10";
    wr(1, 32'h0000_0105); idle(2);
    wr(1, 32'h0100_0001); idle(N + 2);
    cur_req = "R7";
    wr(1, 32'h0100_0001); idle(2);
    wr(2, 32'hC000_0000); idle(N + 2);
    wr(2, 32'hC000_0000); rd(2); idle(2);

    $display("  Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule